// File: doc/BRIEF.md
# Byte-Serial Micro-Task Datapath Sequencer

This block is a small specialised execution engine. It holds an 8-bit ALU, a register file, a local RAM and a constant ROM, and a control FSM drives them. Each command names an operation, a width code, two operand sources with their base addresses, and a destination with its base address. The engine runs that operation on a 1-, 2- or 4-byte operand. A wider operation is broken into byte steps, one per clock. The least significant byte goes first, and the carry or borrow of each step feeds the next step.

The ALU operand multiplexers take bytes straight from the register file, the RAM or the ROM, so no separate load or store step is needed. RAM accesses can be addressed either by the command field or by a pointer register. That pointer is itself written from an ALU result. Results go to the register file, the RAM, the pointer, or an 8-bit peripheral output port. Flags for the whole multi-byte result are held after each command.

Top module: `bytewise_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `flag_z_o`, `flag_c_o`, `port_we_o` and `port_o` are 0, and every register file and RAM byte reads as 0.
- R2: Operation codes: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 invert A, 7 pass B.
- R3: Width code 0 processes 1 byte, 1 processes 2 bytes, and 2 or 3 process 4 bytes. Byte i uses base address plus i, wrapped modulo the depth of the store it touches. `start` is accepted on a clock edge where `busy_o` is 0. Byte i is written on the (i+1)-th edge after that edge. `done_o` is high for exactly the one cycle after the last byte is written.
- R4: Bytes are processed least significant first. The carry (add) or borrow (subtract) out of each byte step is the carry or borrow into the next step, and the first step has none.
- R5: `flag_c_o` is the carry or borrow out of the final byte for add or subtract, and 0 for every other operation.
- R6: `flag_z_o` is 1 exactly when every result byte of the command is zero.
- R7: Source select: 0 register file, 1 RAM, 2 or 3 ROM. ROM byte k holds (29*k + 7) mod 256.
- R8: Destination select: 0 register file, 1 RAM, 2 port, 3 pointer. A port write updates `port_o` and raises `port_we_o` for one cycle per byte. A pointer write loads the low address bits of each result byte, so the final byte wins.
- R9: With `ind_i` = 1, every RAM read and write of the command uses pointer plus i instead of its address field.
- R10: `start` and all command inputs are ignored while busy. The command latched at acceptance runs to completion unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a command when idle |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Operand width code |
| sel_a_i | input | 2 | Source select for operand A |
| sel_b_i | input | 2 | Source select for operand B |
| addr_a_i | input | AW | Base address of operand A |
| addr_b_i | input | AW | Base address of operand B |
| dst_i | input | 2 | Destination select |
| addr_d_i | input | AW | Base address of destination |
| ind_i | input | 1 | Use pointer for RAM addressing |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flag_z_o | output | 1 | Whole-result zero flag |
| flag_c_o | output | 1 | Final carry or borrow flag |
| port_o | output | 8 | Peripheral output byte |
| port_we_o | output | 1 | Port write strobe, one per byte |

## Verification
A fault in the step counter or the width decode shows at `done_o` on the very command where it occurs. The pulse comes a cycle early or late, and the number of `port_we_o` strobes is wrong. A broken carry chain or zero accumulator leaves the low byte correct and corrupts only the higher bytes and the flags. For that reason each command's flags and every port byte are compared, on the cycle that command finishes. A corrupted store or pointer is seen only when the bytes are read back. So each write to the register file or RAM is followed straight away by a readback of that region through the port.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSA = 3'd5,
    OP_NOTA  = 3'd6,
    OP_PASSB = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_ROM  = 2'd2,
    SRC_ROMX = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DST_RF   = 2'd0,
    DST_RAM  = 2'd1,
    DST_PORT = 2'd2,
    DST_PTR  = 2'd3
  } dst_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] wcode;
    src_e       sa;
    src_e       sb;
    dst_e       dst;
    logic       ind;
  } cmd_t;

  typedef struct packed {
    logic [BW-1:0] res;
    logic          cout;
  } alu_out_t;

  // number of byte steps for a width code
  function automatic logic [2:0] byte_count(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic is_arith(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // one byte step of the ALU with carry / borrow in
  function automatic alu_out_t alu_byte(input op_e op, input logic [BW-1:0] a,
                                        input logic [BW-1:0] b, input logic cin);
    logic [BW:0] t;
    alu_out_t    o;
    case (op)
      OP_ADD:   t = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, cin};
      OP_SUB:   t = {1'b0, a} - {1'b0, b} - {{BW{1'b0}}, cin};
      OP_AND:   t = {1'b0, a & b};
      OP_OR:    t = {1'b0, a | b};
      OP_XOR:   t = {1'b0, a ^ b};
      OP_PASSA: t = {1'b0, a};
      OP_NOTA:  t = {1'b0, ~a};
      default:  t = {1'b0, b};
    endcase
    o.res  = t[BW-1:0];
    o.cout = t[BW];
    return o;
  endfunction

  // constant table content, computed rather than listed
  function automatic logic [BW-1:0] rom_byte(input int unsigned idx);
    return BW'(idx * 29 + 7);
  endfunction
endpackage

// File: rtl/bw_ctrl.sv
module bw_ctrl
  import bw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cmd_t          cmd_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [AW-1:0] addr_d_i,
  output logic          run_o,
  output logic          first_o,
  output logic          last_o,
  output logic [1:0]    step_o,
  output cmd_t          cmd_o,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [AW-1:0] addr_d_o,
  output logic          done_o
);
  logic       run_q, done_q;
  logic [1:0] step_q;
  cmd_t       cmd_q;
  logic [2:0] nb;

  assign nb      = byte_count(cmd_q.wcode);
  assign last_o  = run_q && ({1'b0, step_q} == nb - 3'd1);
  assign first_o = run_q && (step_q == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      step_q   <= 2'd0;
      cmd_q    <= '0;
      addr_a_o <= '0;
      addr_b_o <= '0;
      addr_d_o <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_o;
      if (!run_q) begin
        if (start) begin
          run_q    <= 1'b1;
          step_q   <= 2'd0;
          cmd_q    <= cmd_i;
          addr_a_o <= addr_a_i;
          addr_b_o <= addr_b_i;
          addr_d_o <= addr_d_i;
        end
      end else if (last_o) begin
        run_q  <= 1'b0;
        step_q <= 2'd0;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign run_o  = run_q;
  assign step_o = step_q;
  assign cmd_o  = cmd_q;
  assign done_o = done_q;

  a_r10_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_o) |=> run_q);
  a_r10_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_o) |=> (step_q == $past(step_q) + 2'd1));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r3_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          first,
  input  logic          last,
  input  op_e           op,
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] res_o,
  output logic          flag_z_o,
  output logic          flag_c_o
);
  logic     carry_q, zacc_q, cin, zbyte, zall;
  alu_out_t ao;

  assign cin   = first ? 1'b0 : carry_q;
  assign ao    = alu_byte(op, a, b, cin);
  assign zbyte = (ao.res == '0);
  assign zall  = (first ? 1'b1 : zacc_q) & zbyte;
  assign res_o = ao.res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      zacc_q   <= 1'b0;
      flag_z_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else if (run) begin
      carry_q <= ao.cout;
      zacc_q  <= zall;
      if (last) begin
        flag_z_o <= zall;
        flag_c_o <= is_arith(op) & ao.cout;
      end
    end
  end

  a_r4_carry_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (cin == $past(ao.cout)));
  a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last && !is_arith(op)) |=> !flag_c_o);
  a_r6_nonzero_byte_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last && !zbyte) |=> !flag_z_o);
endmodule

// File: rtl/bw_store.sv
module bw_store
  import bw_pkg::*;
#(
  parameter int RF_DEPTH  = 8,
  parameter int RAM_DEPTH = 16,
  parameter int ROM_DEPTH = 16,
  parameter int AW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    step,
  input  src_e          sa,
  input  src_e          sb,
  input  dst_e          dst,
  input  logic          ind,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [AW-1:0] addr_d,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] a_byte_o,
  output logic [BW-1:0] b_byte_o,
  output logic [BW-1:0] port_o,
  output logic          port_we_o
);
  localparam int RFW = $clog2(RF_DEPTH);
  localparam int RMW = $clog2(RAM_DEPTH);
  localparam int ROW = $clog2(ROM_DEPTH);

  logic [BW-1:0]  rf_q  [RF_DEPTH];
  logic [BW-1:0]  ram_q [RAM_DEPTH];
  logic [RMW-1:0] ptr_q;
  logic [RMW-1:0] ptr_idx;
  logic [AW-1:0]  rd_base [2];
  src_e           rd_sel  [2];

  assign ptr_idx    = RMW'(ptr_q + RMW'(step));
  assign rd_base[0] = addr_a;
  assign rd_base[1] = addr_b;
  assign rd_sel[0]  = sa;
  assign rd_sel[1]  = sb;

  // one operand multiplexer per ALU input
  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [AW-1:0] off;
    logic [BW-1:0] val;
    assign off = rd_base[p] + AW'(step);
    always_comb begin
      case (rd_sel[p])
        SRC_RF:  val = rf_q[RFW'(off)];
        SRC_RAM: val = ram_q[ind ? ptr_idx : RMW'(off)];
        default: val = rom_byte(int'(ROW'(off)));
      endcase
    end
  end

  assign a_byte_o = g_rd[0].val;
  assign b_byte_o = g_rd[1].val;

  logic [AW-1:0]  woff;
  logic [RFW-1:0] wrf;
  logic [RMW-1:0] wram;
  assign woff = addr_d + AW'(step);
  assign wrf  = RFW'(woff);
  assign wram = ind ? ptr_idx : RMW'(woff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_DEPTH; i++)  rf_q[i]  <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
      ptr_q     <= '0;
      port_o    <= '0;
      port_we_o <= 1'b0;
    end else begin
      port_we_o <= 1'b0;
      if (run) begin
        case (dst)
          DST_RF:   rf_q[wrf]   <= wdata;
          DST_RAM:  ram_q[wram] <= wdata;
          DST_PORT: begin
            port_o    <= wdata;
            port_we_o <= 1'b1;
          end
          default:  ptr_q <= RMW'(wdata);
        endcase
      end
    end
  end

  a_r8_port_we_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    port_we_o |-> $past(run));
  a_r8_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !port_we_o |-> $stable(port_o));
endmodule

// File: rtl/bytewise_engine.sv
module bytewise_engine
  import bw_pkg::*;
#(
  parameter int RF_DEPTH  = 8,
  parameter int RAM_DEPTH = 16,
  parameter int ROM_DEPTH = 16,
  localparam int MAXD     = (RF_DEPTH > RAM_DEPTH)
                            ? ((RF_DEPTH > ROM_DEPTH) ? RF_DEPTH : ROM_DEPTH)
                            : ((RAM_DEPTH > ROM_DEPTH) ? RAM_DEPTH : ROM_DEPTH),
  localparam int AW       = $clog2(MAXD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_i,
  input  logic [1:0]    width_i,
  input  logic [1:0]    sel_a_i,
  input  logic [1:0]    sel_b_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [1:0]    dst_i,
  input  logic [AW-1:0] addr_d_i,
  input  logic          ind_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic [7:0]    port_o,
  output logic          port_we_o
);
  cmd_t          cmd_in, cmd_q;
  logic          run, first, last;
  logic [1:0]    step;
  logic [AW-1:0] aa, ab, ad;
  logic [BW-1:0] a_byte, b_byte, res;

  assign cmd_in.op    = op_e'(op_i);
  assign cmd_in.wcode = width_i;
  assign cmd_in.sa    = src_e'(sel_a_i);
  assign cmd_in.sb    = src_e'(sel_b_i);
  assign cmd_in.dst   = dst_e'(dst_i);
  assign cmd_in.ind   = ind_i;

  bw_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_i(cmd_in),
    .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .addr_d_i(addr_d_i),
    .run_o(run), .first_o(first), .last_o(last), .step_o(step), .cmd_o(cmd_q),
    .addr_a_o(aa), .addr_b_o(ab), .addr_d_o(ad), .done_o(done_o)
  );

  bw_store #(.RF_DEPTH(RF_DEPTH), .RAM_DEPTH(RAM_DEPTH), .ROM_DEPTH(ROM_DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step),
    .sa(cmd_q.sa), .sb(cmd_q.sb), .dst(cmd_q.dst), .ind(cmd_q.ind),
    .addr_a(aa), .addr_b(ab), .addr_d(ad), .wdata(res),
    .a_byte_o(a_byte), .b_byte_o(b_byte), .port_o(port_o), .port_we_o(port_we_o)
  );

  bw_alu u_alu (
    .clk(clk), .rst_n(rst_n), .run(run), .first(first), .last(last),
    .op(cmd_q.op), .a(a_byte), .b(b_byte),
    .res_o(res), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  assign busy_o = run;
endmodule

// File: tb/bytewise_engine_test.sv
module bytewise_engine_test;
  localparam int RFD = 8, RAMD = 16, ROMD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, start, ind_i;
  logic [2:0] op_i;
  logic [1:0] width_i, sel_a_i, sel_b_i, dst_i;
  logic [3:0] addr_a_i, addr_b_i, addr_d_i;
  logic       busy_o, done_o, flag_z_o, flag_c_o, port_we_o;
  logic [7:0] port_o;

  bytewise_engine uut (.*);

  int checks = 0, fails = 0;
  logic [7:0] m_rf [RFD];
  logic [7:0] m_ram [RAMD];
  logic [3:0] m_ptr;
  logic       m_z, m_c;
  logic [7:0] m_port [4];
  logic [7:0] got [4];
  int         ngot, took;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rom(input int k);
    return 8'((k % ROMD) * 29 + 7);
  endfunction

  function automatic int nbytes(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] m_fetch(input int sel, input int addr, input int i, input int ind);
    if (sel == 0) return m_rf[(addr + i) % RFD];
    if (sel == 1) return m_ram[ind ? (m_ptr + i) % RAMD : (addr + i) % RAMD];
    return m_rom(addr + i);
  endfunction

  // whole-width restatement of the command on the model state
  task automatic model(input int op, input int w, input int sa, input int sb, input int aa,
                       input int ab, input int dst, input int ad, input int ind);
    longint unsigned a = 0, b = 0, r = 0, mask;
    int nb = nbytes(w);
    mask = (64'd1 << (8 * nb)) - 1;
    for (int i = 0; i < nb; i++) begin
      a |= longint'(m_fetch(sa, aa, i, ind)) << (8 * i);
      b |= longint'(m_fetch(sb, ab, i, ind)) << (8 * i);
    end
    m_c = 1'b0;
    case (op)
      0: begin r = a + b; m_c = r[8 * nb]; end
      1: begin m_c = (a < b); r = a - b; end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a;
      6: r = ~a;
      default: r = b;
    endcase
    r &= mask;
    m_z = (r == 0);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] byt = 8'(r >> (8 * i));
      m_port[i] = byt;
      case (dst)
        0: m_rf[(ad + i) % RFD] = byt;
        1: m_ram[ind ? (m_ptr + i) % RAMD : (ad + i) % RAMD] = byt;
        2: ;
        default: ;
      endcase
    end
    if (dst == 3) m_ptr = 4'(r >> (8 * (nb - 1)));
  endtask

  task automatic run_op(input int op, input int w, input int sa, input int sb, input int aa,
                        input int ab, input int dst, input int ad, input int ind, input bit hold);
    int nb = nbytes(w);
    @(negedge clk);
    op_i = 3'(op); width_i = 2'(w); sel_a_i = 2'(sa); sel_b_i = 2'(sb);
    addr_a_i = 4'(aa); addr_b_i = 4'(ab); dst_i = 2'(dst); addr_d_i = 4'(ad); ind_i = 1'(ind);
    start = 1'b1;
    model(op, w, sa, sb, aa, ab, dst, ad, ind);
    ngot = 0; took = 0;
    forever begin
      @(negedge clk);
      took++;
      if (took == 1) begin
        if (hold) begin
          // R10: scramble command while busy, start held high
          op_i = ~op_i; width_i = 2'd0; dst_i = 2'd0; addr_d_i = ~addr_d_i;
          sel_a_i = 2'd1; addr_a_i = ~addr_a_i;
        end else start = 1'b0;
      end
      if (port_we_o && ngot < 4) begin got[ngot] = port_o; ngot++; end
      if (done_o || took > 12) break;
    end
    start = 1'b0;
    check(took == nb + 1, "R3", "done cycle", took, nb + 1);
    check(ngot == ((dst == 2) ? nb : 0), "R8", "port strobes", ngot, (dst == 2) ? nb : 0);
    for (int i = 0; i < ngot && dst == 2; i++)
      check(got[i] == m_port[i], "R2", "port byte", got[i], m_port[i]);
    check(flag_z_o == m_z, "R6", "zero flag", flag_z_o, m_z);
    check(flag_c_o == m_c, "R5", "carry flag", flag_c_o, m_c);
    @(negedge clk);
    check(!done_o && !busy_o, hold ? "R10" : "R3", "done width / idle", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; op_i = '0; width_i = '0; sel_a_i = '0; sel_b_i = '0;
    addr_a_i = '0; addr_b_i = '0; dst_i = '0; addr_d_i = '0; ind_i = '0;
    for (int i = 0; i < RFD; i++) m_rf[i] = '0;
    for (int i = 0; i < RAMD; i++) m_ram[i] = '0;
    m_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !port_we_o, "R1", "idle after reset", {busy_o, done_o, port_we_o}, 0);
    check(!flag_z_o && !flag_c_o && port_o == 0, "R1", "flags/port reset", {flag_z_o, flag_c_o, port_o}, 0);
    run_op(5, 2, 0, 0, 0, 0, 2, 0, 0, 0);
    check({got[3], got[2], got[1], got[0]} == 0, "R1", "RF cleared", {got[3], got[2], got[1], got[0]}, 0);
    run_op(5, 2, 1, 1, 12, 12, 2, 0, 0, 0);
    check({got[3], got[2], got[1], got[0]} == 0, "R1", "RAM cleared", {got[3], got[2], got[1], got[0]}, 0);

    // R7 ROM source
    run_op(5, 2, 2, 2, 0, 0, 2, 0, 0, 0);
    check({got[3], got[2], got[1], got[0]} == 32'h5E41_2407, "R7", "ROM bytes",
          {got[3], got[2], got[1], got[0]}, 32'h5E41_2407);
    // R6 all-zero result
    run_op(1, 2, 2, 2, 0, 0, 0, 0, 0, 0);
    check(flag_z_o == 1'b1, "R6", "zero over 4 bytes", flag_z_o, 1);
    run_op(6, 2, 0, 0, 0, 0, 0, 4, 0, 0);
    run_op(5, 2, 0, 0, 4, 4, 2, 0, 0, 0);
    check({got[3], got[2], got[1], got[0]} == 32'hFFFF_FFFF, "R8", "RF dest readback",
          {got[3], got[2], got[1], got[0]}, 32'hFFFF_FFFF);
    // R5 borrow: 00 - FF
    run_op(1, 0, 0, 0, 0, 4, 1, 0, 0, 0);
    check(flag_c_o == 1'b1, "R5", "borrow out", flag_c_o, 1);
    // R4 carry ripples through all 4 bytes
    run_op(0, 2, 0, 1, 4, 0, 2, 0, 0, 0);
    check({got[3], got[2], got[1], got[0]} == 0 && flag_c_o, "R4", "ripple carry",
          {flag_c_o, got[3], got[2], got[1], got[0]}, 40'h1_0000_0000);
    // R3 address wrap in the 8-entry register file
    run_op(5, 2, 2, 2, 4, 4, 0, 6, 0, 0);
    run_op(5, 1, 0, 0, 0, 0, 2, 0, 0, 0);
    check({got[1], got[0]} == 16'hD2B5, "R3", "wrap readback", {got[1], got[0]}, 16'hD2B5);
    // R9 pointer loaded from a result, then indirect write and read
    run_op(5, 0, 2, 2, 3, 3, 3, 0, 0, 0);
    run_op(5, 1, 2, 2, 2, 2, 1, 0, 1, 0);
    run_op(5, 1, 1, 1, 14, 14, 2, 0, 0, 0);
    check({got[1], got[0]} == 16'h5E41, "R9", "indirect write", {got[1], got[0]}, 16'h5E41);
    run_op(5, 1, 1, 1, 0, 0, 2, 0, 1, 0);
    check({got[1], got[0]} == 16'h5E41, "R9", "indirect read", {got[1], got[0]}, 16'h5E41);
    // R10 held start and changing inputs while busy
    run_op(0, 1, 2, 2, 8, 9, 2, 0, 0, 1);
    // R3 width code 3 acts as 4 bytes
    run_op(4, 3, 2, 2, 5, 10, 2, 0, 0, 0);

    // random commands, R2 over every opcode
    for (int n = 0; n < 300; n++) begin
      int d = $urandom % 3;
      int op = $urandom % 8, w = $urandom % 4;
      int sa, sb;
      if (d == 0) begin sa = 1 + ($urandom % 2); sb = 1 + ($urandom % 2); end
      else if (d == 1) begin sa = 2 * ($urandom % 2); sb = 2 * ($urandom % 2); end
      else begin sa = $urandom % 4; sb = $urandom % 4; end
      run_op(op, w, sa, sb, $urandom % 16, $urandom % 16, d, $urandom % 16, 0, ($urandom % 5) == 0);
      if (d != 2) run_op(5, 2, d, d, 0, 0, 2, 0, 0, 0);
      if (d != 2) run_op(5, 2, d, d, 4, 4, 2, 0, 0, 0);
      if (d == 1) run_op(7, 2, 0, 1, 0, 8, 2, 0, 0, 0);
      if (d == 1) run_op(7, 2, 0, 1, 0, 12, 2, 0, 0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule